// File: doc/BRIEF.md
# Multichannel DMA Engine with Count-End and Global-Abort Rules

This block runs several independent DMA channels through one word-wide memory request port. Every channel holds a source pointer, a destination pointer, a word count and a small control word. The control word has an enable bit, an interrupt-enable bit and an end flag. Each time the memory side accepts a request, the block moves one word for the channel that owns the request. That channel's pointers then step forward by the word size and its count drops by one. Channels compete in fixed priority, and the lowest index wins.

A channel can stop in two different ways. When its count runs out, it sets its end flag and can raise an interrupt. A channel can also be stopped by software clearing its own enable bit. A global halt stops every channel at once and sets no end flag. The halt comes from an NMI pulse or from an address-error input. Clearing the global master-enable bit has the same effect. In every case the pointers and counts keep the values reached by the last word that completed. So once software clears the halt or sets the master enable again, any channel that is still enabled continues from where it stopped.

The memory port is a valid/ready pair. Once `mem_valid` is raised, it stays high with the same channel and addresses until `mem_ready` is seen high at a clock edge. The word moves on that edge. `mem_valid` then drops for at least one cycle before the next request. The memory side may hold `mem_ready` low for any number of cycles. A stop request never withdraws a request that is already raised: that word completes first, and the stop takes effect after it.

Top module: `dmx_ctrl`

## Requirements
- R1: After reset, every pointer, count and control bit reads 0, `master_en` and `halt_flag` are 0, and `mem_valid` is 0.
- R2: On each accepted word, the owning channel's source and destination pointers each rise by STEP, and its count falls by 1. While the request is pending, `mem_src` and `mem_dst` carry the channel's current pointers.
- R3: When a word takes a channel's count from 1 to 0, the channel's end flag (control bit 2, mirrored on `chan_end`) is set and the channel issues no further requests.
- R4: `dma_irq[c]` is high exactly while channel c has its end flag set and its interrupt-enable bit (control bit 1) set.
- R5: Writing a control word with bit 2 at 0 clears the end flag. Writing bit 2 as 1 leaves the flag unchanged.
- R6: Clearing a channel's enable bit (control bit 0) stops only that channel and does not set its end flag. Its pointers and count keep their reached values, and the other channels still run to completion.
- R7: An `nmi_pulse` or `addr_err` cycle sets `halt_flag`, which stops all channels without setting any end flag and keeps all pointers and counts. Writing the global word with bit 1 at 0 clears the flag, writing bit 1 as 1 does not set it, and enabled channels then resume.
- R8: Clearing the master-enable bit (global bit 0) aborts all channels without setting any end flag and keeps their registers. Setting it again resumes the enabled channels.
- R9: A raised `mem_valid` holds with stable `mem_ch`, `mem_src` and `mem_dst` until accepted, including across a halt. After each accepted word, `mem_valid` is low for at least one cycle. No new request starts while halted or while the master enable is off.
- R10: When several channels are ready, the lowest index is served first and keeps the port until it stops.
- R11: A channel whose count is 0 never requests, even when enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Channel register write strobe |
| cfg_ch | input | CHW | Channel selected for the write |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | AW | Write data (count uses the low CW bits) |
| glb_we | input | 1 | Global word write strobe |
| glb_wdata | input | 2 | Bit 0 master enable; bit 1 halt (0 clears, 1 no effect) |
| nmi_pulse | input | 1 | Sets the halt flag |
| addr_err | input | 1 | Sets the halt flag |
| rd_ch | input | CHW | Channel selected for readback |
| rd_sel | input | 2 | Register selected for readback, same coding as cfg_sel |
| rd_data | output | AW | Readback value (control reads {end, ie, en} in bits 2..0) |
| master_en | output | 1 | Master enable state |
| halt_flag | output | 1 | Global halt flag |
| chan_end | output | NCH | End flags per channel |
| dma_irq | output | NCH | End interrupt requests per channel |
| mem_valid | output | 1 | Word transfer request |
| mem_ready | input | 1 | Memory side accepts the word |
| mem_ch | output | CHW | Channel owning the request |
| mem_src | output | AW | Source address of the word |
| mem_dst | output | AW | Destination address of the word |

## Verification
On every cycle, the assertions check the port handshake: the request holds with stable addresses until it is accepted, a gap follows each word, and no request starts while the block is halted or disabled. They also check that the count drops by one per word, that an end flag rises only on the word that exhausts the count, and that the arbiter picks the lowest ready index. Other behaviour can only be shown by the bench's scenarios. These include the exact pointer sequence seen on the bus, the final register values, interrupt gating and end-flag clearing. They also include stopping a single channel, the three global abort sources with their resume paths, and the difference between a count end and an abort.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  typedef enum logic [1:0] {
    SEL_SRC = 2'd0,
    SEL_DST = 2'd1,
    SEL_CNT = 2'd2,
    SEL_CTL = 2'd3
  } dmx_sel_e;

  localparam int CTL_EN = 0;
  localparam int CTL_IE = 1;
  localparam int CTL_TE = 2;

  localparam int GLB_ME   = 0;
  localparam int GLB_HALT = 1;
endpackage

// File: rtl/dmx_pick.sv
module dmx_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  // R10: the chosen index is ready and no lower index is ready
  always_comb begin
    if (any && !$isunknown(req)) begin
      p_pick_ready_r10: assert (req[idx]);
      for (int i = 0; i < N; i++) begin
        if (i < int'(idx)) p_lowest_first_r10: assert (!req[i]);
      end
    end
  end
endmodule

// File: rtl/dmx_chan.sv
module dmx_chan
  import dmx_pkg::*;
#(
  parameter int AW   = 16,
  parameter int CW   = 8,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  dmx_sel_e      wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          step,
  input  logic          run_ok,
  output logic [AW-1:0] sar,
  output logic [AW-1:0] dar,
  output logic [CW-1:0] cnt,
  output logic          en,
  output logic          ie,
  output logic          te,
  output logic          active
);
  logic wr_src, wr_dst, wr_cnt, wr_ctl;
  assign wr_src = wr_en && (wr_sel == SEL_SRC);
  assign wr_dst = wr_en && (wr_sel == SEL_DST);
  assign wr_cnt = wr_en && (wr_sel == SEL_CNT);
  assign wr_ctl = wr_en && (wr_sel == SEL_CTL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar <= '0;
      dar <= '0;
      cnt <= '0;
      en  <= 1'b0;
      ie  <= 1'b0;
      te  <= 1'b0;
    end else begin
      if (wr_src)    sar <= wr_data;
      else if (step) sar <= sar + AW'(STEP);
      if (wr_dst)    dar <= wr_data;
      else if (step) dar <= dar + AW'(STEP);
      if (wr_cnt)    cnt <= wr_data[CW-1:0];
      else if (step) cnt <= cnt - 1'b1;
      if (wr_ctl) begin
        en <= wr_data[CTL_EN];
        ie <= wr_data[CTL_IE];
      end
      if (step && cnt == CW'(1))          te <= 1'b1;
      else if (wr_ctl && !wr_data[CTL_TE]) te <= 1'b0;
    end
  end

  assign active = run_ok && en && !te && (cnt != '0);

  // R2: each accepted word lowers the count by one
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step && !wr_cnt |=> cnt == $past(cnt) - 1'b1);

  // R3: the end flag only rises on the word that empties the count
  p_end_only_by_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(te) |-> $past(step) && $past(cnt) == CW'(1));
endmodule

// File: rtl/dmx_ctrl.sv
module dmx_ctrl
  import dmx_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int AW   = 16,
  parameter int CW   = 8,
  parameter int STEP = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [1:0]     cfg_sel,
  input  logic [AW-1:0]  cfg_wdata,
  input  logic           glb_we,
  input  logic [1:0]     glb_wdata,
  input  logic           nmi_pulse,
  input  logic           addr_err,
  input  logic [CHW-1:0] rd_ch,
  input  logic [1:0]     rd_sel,
  output logic [AW-1:0]  rd_data,
  output logic           master_en,
  output logic           halt_flag,
  output logic [NCH-1:0] chan_end,
  output logic [NCH-1:0] dma_irq,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic [CHW-1:0] mem_ch,
  output logic [AW-1:0]  mem_src,
  output logic [AW-1:0]  mem_dst
);
  logic           me_q, halt_q, run_ok;
  logic           busy_q;
  logic [CHW-1:0] cur_q, win;
  logic           any_act;
  logic [NCH-1:0] act_v, step_v, en_v, ie_v;
  logic [AW-1:0]  sar_a [NCH];
  logic [AW-1:0]  dar_a [NCH];
  logic [CW-1:0]  cnt_a [NCH];

  // global word: master enable and halt flag (set wins over clear)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      me_q   <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      if (glb_we) me_q <= glb_wdata[GLB_ME];
      if (nmi_pulse || addr_err)             halt_q <= 1'b1;
      else if (glb_we && !glb_wdata[GLB_HALT]) halt_q <= 1'b0;
    end
  end
  assign run_ok    = me_q && !halt_q;
  assign master_en = me_q;
  assign halt_flag = halt_q;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign step_v[g] = busy_q && mem_ready && (cur_q == CHW'(g));
    dmx_chan #(.AW(AW), .CW(CW), .STEP(STEP)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we && (cfg_ch == CHW'(g))),
      .wr_sel  (dmx_sel_e'(cfg_sel)),
      .wr_data (cfg_wdata),
      .step    (step_v[g]),
      .run_ok  (run_ok),
      .sar     (sar_a[g]),
      .dar     (dar_a[g]),
      .cnt     (cnt_a[g]),
      .en      (en_v[g]),
      .ie      (ie_v[g]),
      .te      (chan_end[g]),
      .active  (act_v[g])
    );
    assign dma_irq[g] = chan_end[g] && ie_v[g];
  end

  dmx_pick #(.N(NCH), .IW(CHW)) u_pick (
    .req (act_v),
    .any (any_act),
    .idx (win)
  );

  // one word in flight; a raised request is held until accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
    end else if (busy_q) begin
      if (mem_ready) busy_q <= 1'b0;
    end else if (any_act) begin
      busy_q <= 1'b1;
      cur_q  <= win;
    end
  end

  assign mem_valid = busy_q;
  assign mem_ch    = cur_q;
  assign mem_src   = sar_a[cur_q];
  assign mem_dst   = dar_a[cur_q];

  always_comb begin
    unique case (dmx_sel_e'(rd_sel))
      SEL_SRC: rd_data = sar_a[rd_ch];
      SEL_DST: rd_data = dar_a[rd_ch];
      SEL_CNT: rd_data = AW'(cnt_a[rd_ch]);
      default: rd_data = AW'({chan_end[rd_ch], ie_v[rd_ch], en_v[rd_ch]});
    endcase
  end

  // R9: request is held with stable channel and addresses until accepted
  p_hold_until_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_ch) && $stable(mem_src) && $stable(mem_dst));

  // R9: every accepted word is followed by an idle cycle
  p_gap_after_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready |=> !mem_valid);

  // R7 and R8: no request starts while halted or master-disabled
  p_no_start_when_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid && !(master_en && !halt_flag) |=> !mem_valid);
endmodule

// File: tb/test_dmx_ctrl.sv
module test_dmx_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        glb_we = 1'b0;
  logic [1:0]  glb_wdata = '0;
  logic        nmi_pulse = 1'b0;
  logic        addr_err = 1'b0;
  logic [1:0]  rd_ch = '0;
  logic [1:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        master_en, halt_flag, mem_valid;
  logic        mem_ready = 1'b0;
  logic [3:0]  chan_end, dma_irq;
  logic [1:0]  mem_ch;
  logic [15:0] mem_src, mem_dst;

  dmx_ctrl i_dmx_ctrl (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, rmode = 0, nlog = 0;
  int hs [4];
  logic [15:0] exp_src [4];
  logic [15:0] exp_dst [4];
  int log_ch [64];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ready pattern: 0 always, 1 every other cycle, 2 one in three, 3 never
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2;
    case (rmode)
      0: mem_ready = 1'b1;
      1: mem_ready = cyc[0];
      2: mem_ready = (cyc % 3) == 0;
      default: mem_ready = 1'b0;
    endcase
  end

  // R2: every accepted word carries the expected pointers
  always @(negedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      chk(mem_src == exp_src[mem_ch], "R2 src on bus", mem_src, exp_src[mem_ch]);
      chk(mem_dst == exp_dst[mem_ch], "R2 dst on bus", mem_dst, exp_dst[mem_ch]);
      exp_src[mem_ch] = exp_src[mem_ch] + 16'd4;
      exp_dst[mem_ch] = exp_dst[mem_ch] + 16'd4;
      hs[mem_ch]++;
      if (nlog < 64) log_ch[nlog] = int'(mem_ch);
      nlog++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr_cfg(input int ch, input int sel, input int d);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_wdata = 16'(d);
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  task automatic wr_glb(input int d);
    @(posedge clk); #2;
    glb_we = 1'b1; glb_wdata = 2'(d);
    @(posedge clk); #2;
    glb_we = 1'b0;
  endtask

  task automatic rd(input int ch, input int sel, output int v);
    rd_ch = 2'(ch); rd_sel = 2'(sel);
    #1;
    v = int'(rd_data);
  endtask

  task automatic prog(input int ch, input int s, input int d, input int n, input int ctl);
    wr_cfg(ch, 0, s);
    wr_cfg(ch, 1, d);
    wr_cfg(ch, 2, n);
    exp_src[ch] = 16'(s);
    exp_dst[ch] = 16'(d);
    hs[ch] = 0;
    wr_cfg(ch, 3, ctl);
  endtask

  task automatic wait_end(input int ch, input string tag);
    int k = 0;
    while (!chan_end[ch] && k < 2000) begin tick(1); k++; end
    chk(chan_end[ch] == 1'b1, tag, chan_end[ch], 1);
    tick(2);
  endtask

  task automatic wait_hs(input int ch, input int n);
    int k = 0;
    while (hs[ch] < n && k < 2000) begin tick(1); k++; end
  endtask

  // abort scenario: kind 0 nmi, 1 addr_err, 2 master enable off
  task automatic abort_case(input int ch, input int kind, input string tag);
    int v, h0;
    prog(ch, 16'h4000 + ch * 16'h200, 16'hA000 + ch * 16'h200, 30, 1);
    wait_hs(ch, 5);
    @(posedge clk); #2;
    if (kind == 0) nmi_pulse = 1'b1;
    if (kind == 1) addr_err = 1'b1;
    if (kind == 2) begin glb_we = 1'b1; glb_wdata = 2'b00; end
    @(posedge clk); #2;
    nmi_pulse = 1'b0; addr_err = 1'b0; glb_we = 1'b0;
    tick(4);
    h0 = hs[ch];
    tick(12);
    chk(hs[ch] == h0 && !mem_valid, {tag, " all stopped"}, hs[ch], h0);
    chk(chan_end[ch] == 1'b0, {tag, " no end flag"}, chan_end[ch], 0);
    rd(ch, 2, v);
    chk(v == 30 - h0, {tag, " count kept"}, v, 30 - h0);
    rd(ch, 0, v);
    chk(v == int'(exp_src[ch]), {tag, " src kept"}, v, exp_src[ch]);
    if (kind == 2) begin
      chk(master_en == 1'b0, "R8 master off", master_en, 0);
    end else begin
      chk(halt_flag == 1'b1, {tag, " halt set"}, halt_flag, 1);
      wr_glb(3);
      tick(4);
      chk(halt_flag == 1'b1 && hs[ch] == h0, "R7 writing 1 keeps halt", halt_flag, 1);
    end
    wr_glb(1);
    wait_end(ch, {tag, " resumes to end"});
    chk(hs[ch] == 30, {tag, " total words"}, hs[ch], 30);
    rd(ch, 2, v);
    chk(v == 0, {tag, " count empty"}, v, 0);
    wr_cfg(ch, 3, 0);
  endtask

  initial begin
    int v;
    for (int c = 0; c < 4; c++) begin hs[c] = 0; exp_src[c] = '0; exp_dst[c] = '0; end
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1: reset state
    chk(!mem_valid && !master_en && !halt_flag && chan_end == 4'b0, "R1 idle outputs", mem_valid, 0);
    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s < 4; s++) begin
        rd(c, s, v);
        chk(v == 0, "R1 register zero", v, 0);
      end
    end

    // R2 R3 R4 R5: sweep channels, lengths and ready patterns
    wr_glb(1);
    for (int c = 0; c < 4; c++) begin
      for (int n = 1; n <= 6; n++) begin
        int ie = (n + c) % 2;
        int s0 = 16'h1000 + c * 16'h100 + n * 16'h20;
        rmode = n % 3;
        prog(c, s0, s0 + 16'h6000, n, 1 + 2 * ie);
        wait_end(c, "R3 count end");
        rd(c, 0, v);
        chk(v == s0 + 4 * n, "R2 final src", v, s0 + 4 * n);
        rd(c, 1, v);
        chk(v == s0 + 16'h6000 + 4 * n, "R2 final dst", v, s0 + 16'h6000 + 4 * n);
        rd(c, 2, v);
        chk(v == 0, "R3 count zero", v, 0);
        chk(hs[c] == n && !mem_valid, "R3 no further words", hs[c], n);
        chk(dma_irq[c] == ie[0], "R4 irq gated by ie", dma_irq[c], ie);
        if (n == 1) begin
          wr_cfg(c, 3, 4);
          tick(1);
          chk(chan_end[c] == 1'b1, "R5 write 1 keeps end", chan_end[c], 1);
        end
        wr_cfg(c, 3, 0);
        tick(1);
        chk(chan_end[c] == 1'b0 && dma_irq[c] == 1'b0, "R5 end cleared", chan_end[c], 0);
      end
    end
    rmode = 0;

    // R10: fixed priority
    wr_glb(0);
    prog(2, 16'h3000, 16'h3800, 3, 1);
    prog(1, 16'h2000, 16'h2800, 3, 1);
    nlog = 0;
    wr_glb(1);
    wait_end(2, "R10 both finish");
    for (int i = 0; i < 6; i++) begin
      chk(log_ch[i] == (i < 3 ? 1 : 2), "R10 lowest index first", log_ch[i], i < 3 ? 1 : 2);
    end
    wr_cfg(1, 3, 0);
    wr_cfg(2, 3, 0);

    // R6: disabling one channel
    rmode = 1;
    prog(0, 16'h5000, 16'h5800, 20, 1);
    prog(3, 16'h6000, 16'h6800, 5, 1);
    wait_hs(0, 4);
    wr_cfg(0, 3, 0);
    wait_end(3, "R6 other channel completes");
    chk(hs[3] == 5, "R6 other channel words", hs[3], 5);
    chk(chan_end[0] == 1'b0, "R6 no end flag", chan_end[0], 0);
    rd(0, 2, v);
    chk(v == 20 - hs[0] && hs[0] < 20, "R6 count kept", v, 20 - hs[0]);
    rd(0, 0, v);
    chk(v == int'(exp_src[0]), "R6 src kept", v, exp_src[0]);
    wr_cfg(3, 3, 0);
    rmode = 0;

    // R7 and R8: global aborts
    abort_case(2, 0, "R7 nmi");
    abort_case(3, 1, "R7 addr_err");
    abort_case(1, 2, "R8 master");

    // R9: a pending word survives a halt and then completes
    rmode = 3;
    prog(0, 16'h7000, 16'h7800, 4, 1);
    tick(4);
    chk(mem_valid == 1'b1, "R9 request raised", mem_valid, 1);
    @(posedge clk); #2; nmi_pulse = 1'b1;
    @(posedge clk); #2; nmi_pulse = 1'b0;
    tick(5);
    chk(mem_valid == 1'b1 && mem_src == 16'h7000, "R9 request held", mem_src, 16'h7000);
    rmode = 0;
    tick(6);
    chk(hs[0] == 1 && !mem_valid, "R9 one word then stop", hs[0], 1);
    rd(0, 2, v);
    chk(v == 3, "R9 count after pending word", v, 3);
    wr_glb(1);
    wait_end(0, "R9 resume");
    wr_cfg(0, 3, 0);

    // R11: zero count never requests
    prog(1, 16'h1234, 16'h4321, 0, 1);
    tick(20);
    chk(hs[1] == 0 && !mem_valid && !chan_end[1], "R11 zero count idle", hs[1], 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=%0d exp=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule